// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Sign Output

This block holds the working accumulator of a small single-address processor and performs every arithmetic and logic step that the microcode applies to it. Each cycle it can take a second operand from the buffer-register path and a 4-bit operation code, and it writes the result back into the accumulator on the rising clock edge. The operation codes match the instruction opcodes, so the control store forwards the opcode field unchanged.

A separate clear strobe forces the accumulator to zero. A load is built from this strobe: a clear in one step, then an add of the fetched word in the next. The accumulator value goes out for store operations. Its top bit also goes out on its own, and the sequencer reads it to decide the conditional jump: when the bit is zero the jump is taken, and otherwise the program counter steps on.

Top module: `acc_alu_top`

## Requirements
- R1: While rst_n is low the accumulator holds 0000h; after reset it stays 0000h until an operation or clear changes it.
- R2: With op_en_i high and code 3h, the accumulator becomes accumulator plus operand, modulo 2^16.
- R3: With op_en_i high and code 4h, the accumulator becomes accumulator minus operand, modulo 2^16.
- R4: With op_en_i high, code 6h gives the bitwise AND of accumulator and operand, and code 7h gives the bitwise OR.
- R5: With op_en_i high and code 8h, the accumulator becomes its own bitwise complement. The operand is ignored.
- R6: With op_en_i high, code 9h shifts the accumulator right by one bit with a zero entering bit 15. Code Ah shifts it left by one bit with a zero entering bit 0.
- R7: With op_en_i high and code Bh, the accumulator becomes the low 16 bits of accumulator times operand.
- R8: When acc_clr_i is high the accumulator becomes 0000h on the next edge, even if an operation is requested in the same cycle.
- R9: Codes 0h, 1h, 2h, 5h and Ch through Fh leave the accumulator unchanged. Any code leaves it unchanged while op_en_i is low.
- R10: sign_o always equals bit 15 of acc_o.
- R11: Every change takes effect one clock edge after the inputs are presented. acc_o shows the new value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_i | input | 16 | Second operand from the buffer register |
| op_code_i | input | 4 | Operation code, same value as the instruction opcode |
| op_en_i | input | 1 | Applies the operation code this cycle |
| acc_clr_i | input | 1 | Forces the accumulator to zero; has priority |
| acc_o | output | 16 | Accumulator value |
| sign_o | output | 1 | Accumulator bit 15, used by the conditional jump |

## Verification
Some properties are checked on every cycle. These are: the clear result and its priority, hold when idle or on an unlisted code, complement, add and subtract against the previous value, and the zero fill on each shift. Other behaviour only shows up across the bench's instruction-like sequences. These are the multiply truncation and its worked sum, load as clear-then-add, carry and borrow wrap, and a sign bit that follows each result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int ALU_CODE_W = 4;

   localparam logic [ALU_CODE_W-1:0] OP_ADD = 4'h3;
   localparam logic [ALU_CODE_W-1:0] OP_SUB = 4'h4;
   localparam logic [ALU_CODE_W-1:0] OP_AND = 4'h6;
   localparam logic [ALU_CODE_W-1:0] OP_OR  = 4'h7;
   localparam logic [ALU_CODE_W-1:0] OP_INV = 4'h8;
   localparam logic [ALU_CODE_W-1:0] OP_SHR = 4'h9;
   localparam logic [ALU_CODE_W-1:0] OP_SHL = 4'hA;
   localparam logic [ALU_CODE_W-1:0] OP_MUL = 4'hB;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter bit MUL_EN = 1'b1
) (
   input  logic [DATA_W-1:0]     acc_i,
   input  logic [DATA_W-1:0]     opnd_i,
   input  logic [ALU_CODE_W-1:0] code_i,
   output logic [DATA_W-1:0]     res_o,
   output logic                  hit_o
);
   logic [DATA_W-1:0] mul_res;
   logic              mul_hit;

   // The product is kept at DATA_W bits, so the high half is dropped (R7).
   generate
      if (MUL_EN) begin : g_mul
         assign mul_res = acc_i * opnd_i;
         assign mul_hit = 1'b1;
      end else begin : g_no_mul
         assign mul_res = '0;
         assign mul_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      res_o = acc_i;
      hit_o = 1'b1;
      case (code_i)
         OP_ADD: res_o = acc_i + opnd_i;
         OP_SUB: res_o = acc_i - opnd_i;
         OP_AND: res_o = acc_i & opnd_i;
         OP_OR:  res_o = acc_i | opnd_i;
         OP_INV: res_o = ~acc_i;
         OP_SHR: res_o = {1'b0, acc_i[DATA_W-1:1]};
         OP_SHL: res_o = {acc_i[DATA_W-2:0], 1'b0};
         OP_MUL: begin
            res_o = mul_res;
            hit_o = mul_hit;
         end
         default: hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_alu_reg.sv
module acc_alu_reg #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] nxt_i,
   output logic [DATA_W-1:0] acc_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      acc_o <= '0;
      else if (clr_i)  acc_o <= '0;
      else if (load_i) acc_o <= nxt_i;
   end
endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter bit MUL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [3:0]        op_code_i,
   input  logic              op_en_i,
   input  logic              acc_clr_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              sign_o
);
   localparam int SIGN_BIT = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("acc_alu_top: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] alu_res;
   logic              alu_hit;

   acc_alu_logic #(.DATA_W(DATA_W), .MUL_EN(MUL_EN)) u_logic (
      .acc_i  (acc_o),
      .opnd_i (opnd_i),
      .code_i (op_code_i),
      .res_o  (alu_res),
      .hit_o  (alu_hit)
   );

   acc_alu_reg #(.DATA_W(DATA_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (acc_clr_i),
      .load_i (op_en_i & alu_hit),
      .nxt_i  (alu_res),
      .acc_o  (acc_o)
   );

   assign sign_o = acc_o[SIGN_BIT];

   // Clear wins over any operation in the same cycle.
   p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_clr_i |=> (acc_o == '0));

   // Idle cycles keep the accumulator.
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr_i && !op_en_i) |=> $stable(acc_o));

   p_unlisted_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr_i && op_en_i && (op_code_i == 4'h5 || op_code_i == 4'h0)) |=> $stable(acc_o));

   p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr_i && op_en_i && op_code_i == OP_ADD) |=> (acc_o == $past(acc_o) + $past(opnd_i)));

   p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr_i && op_en_i && op_code_i == OP_SUB) |=> (acc_o == $past(acc_o) - $past(opnd_i)));

   p_invert_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr_i && op_en_i && op_code_i == OP_INV) |=> (acc_o == ~$past(acc_o)));

   p_shr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr_i && op_en_i && op_code_i == OP_SHR) |=> (acc_o[SIGN_BIT] == 1'b0));

   p_shl_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_clr_i && op_en_i && op_code_i == OP_SHL) |=> (acc_o[0] == 1'b0));
endmodule

// File: tb/acc_alu_top_bench.sv
module acc_alu_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] opnd_i = '0;
   logic [3:0]  op_code_i = '0;
   logic        op_en_i = 1'b0;
   logic        acc_clr_i = 1'b0;
   logic [15:0] acc_o;
   logic        sign_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] model = '0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   acc_alu_top u_acc_alu_top (
      .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .op_code_i(op_code_i),
      .op_en_i(op_en_i), .acc_clr_i(acc_clr_i), .acc_o(acc_o), .sign_o(sign_o)
   );

   function automatic logic [15:0] ref_step(logic [15:0] a, logic [15:0] b,
                                            logic [3:0] c, logic en, logic clr);
      logic [31:0] p;
      if (clr) return 16'h0000;
      if (!en) return a;
      case (c)
         4'h3: return a + b;
         4'h4: return a - b;
         4'h6: return a & b;
         4'h7: return a | b;
         4'h8: return ~a;
         4'h9: return a >> 1;
         4'hA: return a << 1;
         4'hB: begin p = {16'h0, a} * {16'h0, b}; return p[15:0]; end
         default: return a;
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Driver: presents one step and queues the expected accumulator.
   task automatic step(logic clr, logic en, logic [3:0] c, logic [15:0] b, string tag);
      @(negedge clk);
      acc_clr_i = clr; op_en_i = en; op_code_i = c; opnd_i = b;
      model = ref_step(model, b, c, en, clr);
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   // Monitor: one edge after presentation (R11), compare value and sign (R10).
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [15:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({t, " R11"}, acc_o, e);
         check({t, " R10 sign"}, {15'h0, sign_o}, {15'h0, e[15]});
      end
   end

   initial begin
      #400000;
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", acc_o, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", acc_o, 16'h0000);

      // load 0016h by clear then add, add 000Ah (R2, R8)
      step(1, 0, 4'h0, 16'h0000, "R8 clear");
      step(0, 1, 4'h3, 16'h0016, "R2 load add");
      step(0, 1, 4'h3, 16'h000A, "R2 add");
      // subtract (R3)
      step(1, 0, 4'h0, 16'h0, "R8 clear");
      step(0, 1, 4'h3, 16'h0016, "R2 load");
      step(0, 1, 4'h4, 16'h000A, "R3 sub");
      step(0, 1, 4'h4, 16'h000D, "R3 borrow wrap");
      step(0, 1, 4'h3, 16'h0003, "R2 carry wrap");
      // 13*10+22 = 0098h (R7)
      step(1, 0, 4'h0, 16'h0, "R8 clear");
      step(0, 1, 4'h3, 16'h000D, "R2 load");
      step(0, 1, 4'hB, 16'h000A, "R7 mul");
      step(0, 1, 4'h3, 16'h0016, "R2 add");
      step(0, 1, 4'hB, 16'h0300, "R7 mul truncate");
      // logic ops (R4, R5)
      step(1, 0, 4'h0, 16'h0, "R8 clear");
      step(0, 1, 4'h7, 16'hA5C3, "R4 or");
      step(0, 1, 4'h6, 16'h0FF0, "R4 and");
      step(0, 1, 4'h8, 16'h1234, "R5 invert");
      // shifts (R6)
      step(1, 0, 4'h0, 16'h0, "R8 clear");
      step(0, 1, 4'h7, 16'h8001, "R4 or");
      step(0, 1, 4'h9, 16'hFFFF, "R6 shr");
      step(0, 1, 4'h8, 16'h0, "R5 invert");
      step(0, 1, 4'hA, 16'hFFFF, "R6 shl");
      step(0, 1, 4'hA, 16'h0, "R6 shl");
      // unlisted codes and disabled op (R9)
      step(0, 1, 4'h0, 16'h1111, "R9 code0");
      step(0, 1, 4'h5, 16'h1111, "R9 code5");
      step(0, 1, 4'h1, 16'h1111, "R9 code1");
      step(0, 1, 4'h2, 16'h1111, "R9 code2");
      step(0, 1, 4'hC, 16'h1111, "R9 codeC");
      step(0, 1, 4'hF, 16'h1111, "R9 codeF");
      step(0, 0, 4'h3, 16'h1111, "R9 disabled");
      // clear priority (R8)
      step(1, 1, 4'h3, 16'h1111, "R8 clear priority");
      step(0, 0, 4'h0, 16'h0, "R9 idle");
      @(negedge clk);
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule